// File: doc/BRIEF.md
# Half-Width Immediate Trap Comparator

This unit decides, one operation at a time, whether a conditional trap fires. It looks only at the lower half of an XLEN-bit register value and treats that half as a signed number. It compares the half with a signed 16-bit immediate in five ways. Each way is enabled by its own bit of a 5-bit condition mask. The request goes high when at least one enabled relation holds.

Both operands are first sign-extended to a common comparison width, the larger of XLEN and 16. The immediate therefore keeps all of its bits, even when the tested half is only a nibble. An execute stage presents the operands together with a valid strobe. The trap request comes back from a register one cycle later. Whatever acts on the trap (vectoring, state save) sits outside this unit.

Top module: `trap_cmp_top`

## Requirements
- R1: While `rst` is high at a clock edge, `trap_req` is 0 after that edge, whatever the other inputs are.
- R2: The tested operand is bits [XLEN/2-1:0] of `reg_val`, taken as signed and sign-extended. The upper half of `reg_val` has no effect on `trap_req`.
- R3: The 16-bit `imm` is taken as signed and sign-extended to the comparison width of max(XLEN,16) bits before every comparison, including the unsigned ones. For example, imm 0xFFFF equals an operand of -1.
- R4: Mask bit 0 enables a trap when the operand is less than the immediate, both taken as signed.
- R5: Mask bit 1 enables a trap when the operand is greater than the immediate, both taken as signed.
- R6: Mask bit 2 enables a trap when the operand equals the immediate.
- R7: Mask bit 3 enables a trap when the operand is less than the immediate, both extended values taken as unsigned.
- R8: Mask bit 4 enables a trap when the operand is greater than the immediate, both extended values taken as unsigned.
- R9: `trap_req` is the OR of all enabled relations that hold. It is high for exactly the one cycle after an edge at which `op_valid` was high, and it is low after any edge at which `op_valid` was low.
- R10: A mask of all zeros never raises `trap_req`.
- R11: With XLEN=8 the operand is the low nibble (range -8..7), compared with the full 16-bit immediate. For example, immediates 0x0008 and 0x8000 are never equal to any nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operands on this cycle form one trap decision |
| reg_val | input | XLEN | Register value; only the lower half is tested |
| imm | input | IMM_W (16) | Signed immediate |
| to_mask | input | 5 | Condition enables: bit0 signed less, bit1 signed greater, bit2 equal, bit3 unsigned less, bit4 unsigned greater |
| trap_req | output | 1 | Registered trap request, one cycle after the valid operation |

## Verification
The signed and unsigned relations can both hold in the same cycle. When the tested half is negative and the immediate is a small positive number, signed-less and unsigned-greater are true together. The OR must then give a single request. If the two enabled relations disagree, the request must still be raised by whichever one holds. The bench provokes these cases by sweeping all 32 masks against every byte value of an 8-bit register and a set of immediates around the sign boundaries. For each combination, the expected request is computed arithmetically from integer operand values.

// File: rtl/trapcmp_pkg.sv
package trapcmp_pkg;

  // Condition bit positions inside the mask; the order is fixed behaviour.
  localparam int NUM_COND = 5;
  localparam int IDX_SLT  = 0;
  localparam int IDX_SGT  = 1;
  localparam int IDX_EQ   = 2;
  localparam int IDX_ULT  = 3;
  localparam int IDX_UGT  = 4;

  // Comparison width: wide enough for both the register and the immediate.
  function automatic int cmp_width(input int xlen, input int immw);
    return (xlen > immw) ? xlen : immw;
  endfunction

endpackage

// File: rtl/trapcmp_half_sext.sv
module trapcmp_half_sext #(
  parameter int XLEN = 64,
  parameter int CW   = 64
) (
  input  logic [XLEN-1:0] reg_in,
  output logic [CW-1:0]   opnd
);
  localparam int HALF = XLEN / 2;

  logic [HALF-1:0] low_half;
  assign low_half = reg_in[HALF-1:0];

  generate
    if (CW > HALF) begin : g_ext
      assign opnd = {{(CW-HALF){low_half[HALF-1]}}, low_half};
    end else begin : g_pass
      assign opnd = low_half[CW-1:0];
    end
  endgenerate

  logic unused_upper;
  assign unused_upper = ^reg_in[XLEN-1:HALF];
endmodule

// File: rtl/trapcmp_imm_sext.sv
module trapcmp_imm_sext #(
  parameter int IMM_W = 16,
  parameter int CW    = 64
) (
  input  logic [IMM_W-1:0] imm_in,
  output logic [CW-1:0]    imm_ext
);
  generate
    if (CW > IMM_W) begin : g_ext
      assign imm_ext = {{(CW-IMM_W){imm_in[IMM_W-1]}}, imm_in};
    end else begin : g_pass
      assign imm_ext = imm_in;
    end
  endgenerate
endmodule

// File: rtl/trapcmp_cond_eval.sv
module trapcmp_cond_eval
  import trapcmp_pkg::*;
#(
  parameter int CW = 64
) (
  input  logic [CW-1:0]       lhs,
  input  logic [CW-1:0]       rhs,
  output logic [NUM_COND-1:0] hit
);
  // One signed and one unsigned magnitude compare plus one equality;
  // the "greater" relations are derived from them.
  logic lt_s, lt_u, same;

  assign same = (lhs == rhs);
  assign lt_s = $signed(lhs) < $signed(rhs);
  assign lt_u = lhs < rhs;

  generate
    for (genvar k = 0; k < NUM_COND; k++) begin : g_cond
      if (k == IDX_SLT) begin : g_slt
        assign hit[k] = lt_s;
      end else if (k == IDX_SGT) begin : g_sgt
        assign hit[k] = !lt_s && !same;
      end else if (k == IDX_EQ) begin : g_eq
        assign hit[k] = same;
      end else if (k == IDX_ULT) begin : g_ult
        assign hit[k] = lt_u;
      end else begin : g_ugt
        assign hit[k] = !lt_u && !same;
      end
    end
  endgenerate
endmodule

// File: rtl/trap_cmp_top.sv
module trap_cmp_top
  import trapcmp_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                op_valid,
  input  logic [XLEN-1:0]     reg_val,
  input  logic [IMM_W-1:0]    imm,
  input  logic [NUM_COND-1:0] to_mask,
  output logic                trap_req
);
  localparam int CW = cmp_width(XLEN, IMM_W);

  logic [CW-1:0]       opnd_ext;
  logic [CW-1:0]       imm_ext;
  logic [NUM_COND-1:0] cond_hit;
  logic                fire;

  trapcmp_half_sext #(.XLEN(XLEN), .CW(CW)) u_half (
    .reg_in (reg_val),
    .opnd   (opnd_ext)
  );

  trapcmp_imm_sext #(.IMM_W(IMM_W), .CW(CW)) u_imm (
    .imm_in  (imm),
    .imm_ext (imm_ext)
  );

  trapcmp_cond_eval #(.CW(CW)) u_eval (
    .lhs (opnd_ext),
    .rhs (imm_ext),
    .hit (cond_hit)
  );

  assign fire = op_valid && (|(cond_hit & to_mask));

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_req <= 1'b0;
    end else begin
      trap_req <= fire;
    end
  end
endmodule

// File: rtl/trap_cmp_checker.sv
module trap_cmp_checker
  import trapcmp_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                op_valid,
  input logic [XLEN-1:0]     reg_val,
  input logic [IMM_W-1:0]    imm,
  input logic [NUM_COND-1:0] to_mask,
  input logic                trap_req
);
  localparam int CW = cmp_width(XLEN, IMM_W);
  localparam int HALF = XLEN / 2;

  logic signed [HALF-1:0]  lo_s;
  logic signed [IMM_W-1:0] im_s;
  logic signed [CW-1:0]    sa, sb;
  logic                    any_true;

  assign lo_s = reg_val[HALF-1:0];
  assign im_s = imm;
  assign sa = CW'(lo_s);
  assign sb = CW'(im_s);
  assign any_true = (to_mask[0] && (sa < sb)) || (to_mask[1] && (sa > sb)) ||
                    (to_mask[2] && (sa == sb)) ||
                    (to_mask[3] && ($unsigned(sa) < $unsigned(sb))) ||
                    (to_mask[4] && ($unsigned(sa) > $unsigned(sb)));

  assert_slt_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && to_mask[0] && (sa < sb)) |=> trap_req);
  assert_sgt_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && to_mask[1] && (sa > sb)) |=> trap_req);
  assert_eq_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && to_mask[2] && (sa == sb)) |=> trap_req);
  assert_ult_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && to_mask[3] && ($unsigned(sa) < $unsigned(sb))) |=> trap_req);
  assert_ugt_R8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && to_mask[4] && ($unsigned(sa) > $unsigned(sb))) |=> trap_req);
  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !trap_req);
  assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !any_true) |=> !trap_req);
  assert_nomask_R10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (to_mask == '0)) |=> !trap_req);
endmodule

bind trap_cmp_top trap_cmp_checker #(.XLEN(XLEN), .IMM_W(IMM_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .reg_val  (reg_val),
  .imm      (imm),
  .to_mask  (to_mask),
  .trap_req (trap_req)
);

// File: tb/trap_cmp_top_test.sv
`timescale 1ns/1ps
module trap_cmp_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;

  logic        v8 = 1'b0, v32 = 1'b0;
  logic [7:0]  r8 = '0;
  logic [31:0] r32 = '0;
  logic [15:0] i8 = '0, i32 = '0;
  logic [4:0]  m8 = '0, m32 = '0;
  logic        t8, t32;

  int n_cmp = 0;
  int n_bad = 0;

  bit    pend = 0;
  bit    pend_exp = 0;
  bit    pend_sel = 0;
  string pend_tag = "";

  longint imm8_set [8]  = '{0, 1, 7, 16'hFFF8, 16'hFFFF, 8, 16'h7FFF, 16'h8000};
  longint reg32_set [6] = '{32'h0000_0005, 32'hFFFF_0005, 32'h1234_8000,
                            32'h0000_7FFF, 32'hABCD_FFFF, 32'h0001_0000};
  longint imm32_set [6] = '{0, 5, 16'hFFFF, 16'h8000, 16'h7FFF, 1};

  always #10 clk = ~clk;

  trap_cmp_top #(.XLEN(8), .IMM_W(16)) uut (
    .clk(clk), .rst(rst), .op_valid(v8), .reg_val(r8), .imm(i8),
    .to_mask(m8), .trap_req(t8)
  );

  trap_cmp_top #(.XLEN(32), .IMM_W(16)) uut_w32 (
    .clk(clk), .rst(rst), .op_valid(v32), .reg_val(r32), .imm(i32),
    .to_mask(m32), .trap_req(t32)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: trap_req=%b expected %b", tag, act, exp);
    end
  endtask

  function automatic bit model(input int xlen, input longint regv,
                               input longint immv, input logic [4:0] m);
    int     h  = xlen / 2;
    int     cw = (xlen > 16) ? xlen : 16;
    longint lo, a, b, ua, ub;
    lo = regv & ((64'sd1 <<< h) - 1);
    a  = (lo >= (64'sd1 <<< (h-1))) ? lo - (64'sd1 <<< h) : lo;
    b  = (immv >= 32768) ? immv - 65536 : immv;
    ua = (a < 0) ? a + (64'sd1 <<< cw) : a;
    ub = (b < 0) ? b + (64'sd1 <<< cw) : b;
    return (m[0] && a < b) || (m[1] && a > b) || (m[2] && a == b) ||
           (m[3] && ua < ub) || (m[4] && ua > ub);
  endfunction

  function automatic string tag_of(input logic [4:0] m);
    case (m)
      5'b00000: return "R10";
      5'b00001: return "R4";
      5'b00010: return "R5";
      5'b00100: return "R6";
      5'b01000: return "R7";
      5'b10000: return "R8";
      default:  return "R9";
    endcase
  endfunction

  task automatic retire();
    if (pend) check(pend_tag, pend_sel ? t32 : t8, pend_exp);
    pend = 0;
  endtask

  task automatic issue(input bit sel, input longint regv, input longint immv,
                       input logic [4:0] m, input string tag);
    @(negedge clk);
    retire();
    if (sel) begin
      v32 = 1'b1; r32 = regv[31:0]; i32 = immv[15:0]; m32 = m; v8 = 1'b0;
    end else begin
      v8 = 1'b1; r8 = regv[7:0]; i8 = immv[15:0]; m8 = m; v32 = 1'b0;
    end
    pend     = 1;
    pend_sel = sel;
    pend_exp = model(sel ? 32 : 8, regv, immv, m);
    pend_tag = tag;
  endtask

  task automatic idle();
    @(negedge clk);
    retire();
    v8  = 1'b0;
    v32 = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run still busy, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: conditions true and valid high while reset is held
    v8 = 1'b1; r8 = 8'h00; i8 = 16'h0000; m8 = 5'b11111;
    v32 = 1'b1; r32 = '0; i32 = '0; m32 = 5'b11111;
    repeat (3) @(negedge clk);
    check("R1 xlen8", t8, 1'b0);
    check("R1 xlen32", t32, 1'b0);
    rst = 1'b0; v8 = 1'b0; v32 = 1'b0;

    // R2: upper half ignored
    issue(0, 8'hF3, 3, 5'b00100, "R2 upper ones");
    issue(0, 8'h03, 3, 5'b00100, "R2 upper zeros");
    issue(1, 32'hFFFF_0005, 5, 5'b00100, "R2 xlen32 upper ones");
    // R3: immediate sign extension, also in unsigned sense
    issue(0, 8'h0F, 16'hFFFF, 5'b00100, "R3 minus one equal");
    issue(0, 8'h08, 16'h8000, 5'b10000, "R3 unsigned greater");
    issue(1, 32'h0000_FFFF, 16'hFFFF, 5'b00100, "R3 xlen32 equal");
    // signed-less and unsigned-greater in the same operation
    issue(0, 8'h0E, 2, 5'b10001, "R9 both relations");
    issue(0, 8'h0E, 2, 5'b01010, "R9 neither relation");
    // R9: one-cycle pulse, then low
    issue(0, 8'h05, 5, 5'b00100, "R9 pulse high");
    idle();
    idle();
    check("R9 pulse drop", t8, 1'b0);
    @(negedge clk);
    r8 = 8'h00; i8 = 16'h0000; m8 = 5'b00100; v8 = 1'b0;
    @(negedge clk);
    check("R9 valid low", t8, 1'b0);

    // R11 sweep: every byte, border immediates, every mask
    for (int r = 0; r < 256; r++)
      for (int k = 0; k < 8; k++)
        for (int m = 0; m < 32; m++)
          issue(0, r, imm8_set[k], m[4:0], {"R11 ", tag_of(m[4:0])});

    // wider configuration sweep
    for (int r = 0; r < 6; r++)
      for (int k = 0; k < 6; k++)
        for (int m = 0; m < 32; m++)
          issue(1, reg32_set[r], imm32_set[k], m[4:0], tag_of(m[4:0]));

    idle();
    idle();
    check("R9 final idle", t32, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule